// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits beside a two-wire bus master and frees the bus when a slave has been left holding the data line low. That can happen after a transfer was cut short, after a reset, or after a power loss. A one-cycle request starts recovery. The sequencer then clocks SCL by pulling it low and releasing it. In each high phase it looks at SDA, and it stops clocking as soon as SDA reads released. It then places a start condition on the bus so that every slave resynchronizes. It finishes with a one-cycle `done` pulse. If the line is still stuck after the allowed number of pulses, it finishes with a one-cycle `fail` pulse instead.

Both lines are handled as open-drain lines. The block only asserts pull-low enables, and it reads the real line levels back through a synchronizer. Because SCL is read back, a device that stretches the clock lengthens the high phase rather than shortening it. The block has no data path, so every pin is a plain control or status signal. After `done`, the master that owns the bus is expected to take over the lines in the next cycle.

Top module: `bus_unjam_seq`

## Requirements
- R1: After reset both pull enables are low, and `busy`, `done` and `fail` are low.
- R2: On an accepted request with SDA low, `scl_pull` rises in the next cycle. Each low phase lasts PHASE_CYCLES cycles. Each high phase lasts PHASE_CYCLES cycles counted from the cycle in which synchronized SCL first reads high, which is PHASE_CYCLES+SYNC_STAGES cycles of line-high time when nothing stretches the clock.
- R3: SDA is sampled, through the synchronizer, at the last cycle of each high phase. Clocking stops after the first high phase in which SDA reads high, so the number of SCL rising edges equals the number of pulses the stuck slave needs.
- R4: If synchronized SDA is already high when the request is accepted, no SCL pulse is produced and the sequencer goes straight to the start condition.
- R5: The start condition pulls SDA low while SCL is released and holds it for PHASE_CYCLES cycles. SCL is then pulled low for PHASE_CYCLES cycles while SDA stays low. SDA never begins to be pulled while SCL is pulled.
- R6: On success `done` is high for exactly one cycle, with both lines still pulled low. In the following cycle both lines are released and `busy` is low.
- R7: At most MAX_PULSES (9) pulses are produced. If SDA still reads low at the end of the last high phase, `fail` is high for exactly one cycle, both lines are released, no start condition is produced, and the sequencer returns to idle.
- R8: A request that arrives while `busy` is high is ignored. The running sequence keeps its pulse count and ends with a single `done`.
- R9: `done` and `fail` are never high together, and neither is high twice in a row.
- R10: While `busy` is low, neither line is pulled.
- R11: While another device holds SCL low after the sequencer has released it, the sequencer waits without ending the high phase, and the pulse count is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | One-cycle request to start recovery; ignored while busy |
| scl_in | input | 1 | Level of the SCL line, asynchronous |
| sda_in | input | 1 | Level of the SDA line, asynchronous |
| scl_pull | output | 1 | When high, SCL is pulled low; when low, SCL is released |
| sda_pull | output | 1 | When high, SDA is pulled low; when low, SDA is released |
| busy | output | 1 | High from an accepted request until the cycle after done or fail |
| done | output | 1 | One-cycle pulse: the bus is free and a start condition has been issued |
| fail | output | 1 | One-cycle pulse: SDA was still low after the last allowed pulse |

## Verification
Two situations are hard to reach from the ports: the boundary between the ninth pulse freeing the line and the ninth pulse failing, and a high phase lengthened by another device holding SCL. The bench models the stuck slave as an open-drain device that counts SCL rising edges on the resolved line and lets SDA go after a chosen count. Counts of 9 and 10 fall on either side of the limit. A separate bench pull on SCL holds the line low well past the nominal high phase. This shows that the sequencer waits, keeps its pulse count and still gives every high phase its full length once the line rises.

// File: rtl/bus_unjam_pkg.sv
package bus_unjam_pkg;

  typedef enum logic [2:0] {
    UJ_IDLE       = 3'd0,
    UJ_DRIVE_LOW  = 3'd1,
    UJ_RELEASE_HI = 3'd2,
    UJ_START_HOLD = 3'd3,
    UJ_CLK_PARK   = 3'd4,
    UJ_DONE       = 3'd5,
    UJ_FAIL       = 3'd6
  } unjam_state_e;

  function automatic int unsigned uj_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= {WIDTH{RESET_VAL}};
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= {WIDTH{RESET_VAL}};
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/unjam_phase_timer.sv
module unjam_phase_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hold,
  output logic expired
);
  import bus_unjam_pkg::*;

  localparam int CW = uj_width(LEN);
  localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else if (load || hold) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/unjam_pulse_count.sv
module unjam_pulse_count #(
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  import bus_unjam_pkg::*;

  localparam int CW = uj_width(MAX_PULSES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_PULSES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q >= LAST_IDX);

endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq #(
  parameter int PHASE_CYCLES = 8,
  parameter int MAX_PULSES   = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done,
  output logic fail
);
  import bus_unjam_pkg::*;

  unjam_state_e state_q, state_d;
  logic [1:0]   line_sync;
  logic         scl_high, sda_high;
  logic         phase_over, at_last_pulse;
  logic         load_timer, hold_timer;
  logic         sample_now, clear_count;

  unjam_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    (line_sync)
  );

  assign scl_high = line_sync[1];
  assign sda_high = line_sync[0];

  unjam_phase_timer #(.LEN(PHASE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_timer),
    .hold   (hold_timer),
    .expired(phase_over)
  );

  unjam_pulse_count #(.MAX_PULSES(MAX_PULSES)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear_count),
    .step (sample_now),
    .last (at_last_pulse)
  );

  assign hold_timer  = (state_q == UJ_RELEASE_HI) && !scl_high;
  assign sample_now  = (state_q == UJ_RELEASE_HI) && phase_over && scl_high;
  assign clear_count = (state_q == UJ_IDLE) && recover_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      UJ_IDLE: begin
        if (recover_req) state_d = sda_high ? UJ_START_HOLD : UJ_DRIVE_LOW;
      end
      UJ_DRIVE_LOW: begin
        if (phase_over) state_d = UJ_RELEASE_HI;
      end
      UJ_RELEASE_HI: begin
        if (sample_now) begin
          if (sda_high)           state_d = UJ_START_HOLD;
          else if (at_last_pulse) state_d = UJ_FAIL;
          else                    state_d = UJ_DRIVE_LOW;
        end
      end
      UJ_START_HOLD: begin
        if (phase_over) state_d = UJ_CLK_PARK;
      end
      UJ_CLK_PARK: begin
        if (phase_over) state_d = UJ_DONE;
      end
      UJ_DONE: state_d = UJ_IDLE;
      UJ_FAIL: state_d = UJ_IDLE;
      default: state_d = UJ_IDLE;
    endcase
  end

  assign load_timer = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UJ_IDLE;
    else        state_q <= state_d;
  end

  assign scl_pull = (state_q == UJ_DRIVE_LOW) || (state_q == UJ_CLK_PARK) ||
                    (state_q == UJ_DONE);
  assign sda_pull = (state_q == UJ_START_HOLD) || (state_q == UJ_CLK_PARK) ||
                    (state_q == UJ_DONE);
  assign busy     = (state_q != UJ_IDLE);
  assign done     = (state_q == UJ_DONE);
  assign fail     = (state_q == UJ_FAIL);

endmodule

// File: rtl/bus_unjam_seq_chk.sv
module bus_unjam_seq_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic recover_req,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done,
  input logic fail
);

  logic [7:0] pull_cnt;
  logic       scl_pull_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_cnt      <= '0;
      scl_pull_prev <= 1'b0;
    end else begin
      scl_pull_prev <= scl_pull;
      if (!busy)                          pull_cnt <= '0;
      else if (scl_pull && !scl_pull_prev) pull_cnt <= pull_cnt + 1'b1;
    end
  end

  // R7: failure only after exactly the full pulse budget
  assert_fail_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (pull_cnt == 8'(MAX_PULSES)));

  // R7: success never spends more than the budget plus the parking pull
  assert_done_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pull_cnt <= 8'(MAX_PULSES + 1)));

  assert_sda_pull_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_pull);

  assert_start_holds_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |=> !scl_pull);

  assert_done_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_pull && sda_pull));

  assert_done_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !(done || fail));

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  assert_req_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && recover_req) |=> busy);

endmodule

bind bus_unjam_seq bus_unjam_seq_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .recover_req(recover_req),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .busy       (busy),
  .done       (done),
  .fail       (fail)
);

// File: tb/bus_unjam_seq_bench.sv
`timescale 1ns/1ps
module bus_unjam_seq_bench;

  localparam int PHASE   = 8;
  localparam int MAXP    = 9;
  localparam int SYNC    = 2;
  localparam int EXP_HI  = PHASE + SYNC;
  localparam int NVEC    = 7;
  localparam int NEED      [NVEC] = '{0, 1, 2, 5, 9, 10, 30};
  localparam int EXP_RISES [NVEC] = '{0, 1, 2, 5, 9, 9, 9};
  localparam int EXP_OK    [NVEC] = '{1, 1, 1, 1, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_req = 1'b0;
  logic scl_pull, sda_pull, busy, done, fail;
  logic slave_low = 1'b0;
  logic stretch = 1'b0;
  wire  scl_line = ~(scl_pull | stretch);
  wire  sda_line = ~(sda_pull | slave_low);

  int tests = 0;
  int fails = 0;
  int need = 0;
  int slave_rises = 0;
  int rises, bad_low, bad_high, start_cyc, starts, n_done, n_fail, lrun, hrun;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  always #2 clk = ~clk;

  bus_unjam_seq #(.PHASE_CYCLES(PHASE), .MAX_PULSES(MAXP), .SYNC_STAGES(SYNC)) u_bus_unjam_seq (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .busy(busy), .done(done), .fail(fail)
  );

  // stuck slave: lets SDA go once it has seen NEED rising edges on SCL
  always @(posedge scl_line) begin
    if (slave_low) begin
      slave_rises = slave_rises + 1;
      if (slave_rises >= need) slave_low = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (busy && scl_line && !prev_scl) rises = rises + 1;
    if (prev_sda && !sda_line && scl_line && prev_scl) starts = starts + 1;
    if (busy && sda_pull && !scl_pull) start_cyc = start_cyc + 1;
    if (done) n_done = n_done + 1;
    if (fail) n_fail = n_fail + 1;
    if (!busy) lrun = 0;
    else if (scl_pull) lrun = lrun + 1;
    else begin
      if (lrun != 0 && lrun != PHASE) bad_low = bad_low + 1;
      lrun = 0;
    end
    if (!busy || sda_pull) hrun = 0;
    else if (scl_line) hrun = hrun + 1;
    else begin
      if (hrun != 0 && hrun != EXP_HI) bad_high = bad_high + 1;
      hrun = 0;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    rises = 0; bad_low = 0; bad_high = 0; start_cyc = 0; starts = 0;
    n_done = 0; n_fail = 0; lrun = 0; hrun = 0;
  endtask

  task automatic arm(input int n);
    need = n;
    slave_rises = 0;
    slave_low = (n != 0);
    repeat (4) @(posedge clk);
    clear_stats();
  endtask

  task automatic request();
    @(posedge clk) recover_req <= 1'b1;
    @(posedge clk) recover_req <= 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || fail) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!scl_pull && !sda_pull, "R1", "lines pulled in reset", int'(scl_pull | sda_pull), 0);
    check(!busy && !done && !fail, "R1", "status in reset", int'(busy | done | fail), 0);
    @(posedge clk) rst_n <= 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NVEC; v++) begin
      arm(NEED[v]);
      request();
      wait_end();
      // R3 R4 R7: rising edges equal the pulses needed, capped at the budget
      check(rises == EXP_RISES[v], "R3", "scl rising edges", rises, EXP_RISES[v]);
      check(n_done == EXP_OK[v], "R6", "done pulses", n_done, EXP_OK[v]);
      check(n_fail == 1 - EXP_OK[v], "R7", "fail pulses", n_fail, 1 - EXP_OK[v]);
      check(starts == EXP_OK[v], "R5", "start conditions", starts, EXP_OK[v]);
      check(start_cyc == EXP_OK[v] * PHASE, "R5", "start hold cycles", start_cyc, EXP_OK[v] * PHASE);
      check(bad_low == 0, "R2", "low phases off length", bad_low, 0);
      check(bad_high == 0, "R2", "high phases off length", bad_high, 0);
      check(!busy && !scl_pull && !sda_pull, "R10", "lines after end",
            int'(busy | scl_pull | sda_pull), 0);
      if (NEED[v] == 0)
        check(rises == 0, "R4", "pulses with sda free", rises, 0);
      slave_low = 1'b0;
      repeat (4) @(posedge clk);
    end

    // R8: second request while busy is ignored
    arm(4);
    request();
    repeat (20) @(posedge clk);
    request();
    wait_end();
    repeat (60) @(negedge clk);
    check(rises == 4, "R8", "pulses with extra request", rises, 4);
    check(n_done == 1, "R8", "done pulses with extra request", n_done, 1);
    check(!busy, "R8", "busy after extra request", int'(busy), 0);

    // R11: another device stretches SCL during the first high phase
    stretch = 1'b1;
    arm(3);
    request();
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(busy && !scl_pull, "R11", "waiting with scl released", int'(busy & ~scl_pull), 1);
    check(rises == 0, "R11", "rises during stretch", rises, 0);
    @(posedge clk) stretch <= 1'b0;
    wait_end();
    check(rises == 3, "R11", "pulses after stretch", rises, 3);
    check(n_done == 1 && n_fail == 0, "R11", "done after stretch", n_done, 1);
    check(bad_high == 0, "R11", "high phases after stretch", bad_high, 0);

    // R1: reset in the middle of a recovery releases everything
    arm(30);
    request();
    repeat (25) @(posedge clk);
    rst_n <= 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!scl_pull && !sda_pull && !busy, "R1", "mid-run reset",
          int'(scl_pull | sda_pull | busy), 0);
    slave_low = 1'b0;
    @(posedge clk) rst_n <= 1'b1;
    repeat (4) @(posedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule